// File: doc/BRIEF.md
# Integrity-Tree Error-Handling Walk Controller

This block sequences error detection and correction for one protected read over a counter integrity tree. It climbs first. It starts at the data line (level 0) and moves up one tree level at a time. At each level an external tag checker reports two things: whether the recomputed tag matched, and whether the level's entry sits in an on-chip cache. A mismatch never stops the climb. It is only noted in a per-level log. The climb ends at the first tree level reported as on-chip, because that entry is trusted. It also ends once the deepest supported tree level has been fetched, in which case the level above it is treated as trusted.

The block then descends from the highest fetched level to the data line. Each logged level is handed to an external reconstruction engine, and the walk moves down only after that engine reports success. An error is therefore always blamed on the line whose own tag disagrees, since every line above it is already verified. A failed repair ends the walk at once and declares an attack. Otherwise the walk ends as clean or corrected, and a bit vector shows which levels were repaired.

The walk states are as follows. IDLE waits for `start`. CLIMB issues the tag check for the current level; a response either advances the level or turns the walk to DESCEND. DESCEND either moves to REPAIR for a logged level, steps down, or goes to FINISH after level 0. REPAIR waits for the engine; success returns to DESCEND (or goes to FINISH after level 0), and failure goes to FINISH with an attack. FINISH lasts one cycle and returns to IDLE.

Top module: `tree_fix_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `chk_req`, `fix_req` and `done` are 0, `result` is 0 and `fixed_vec` is all zero.
- R2: A `start` seen while idle clears the previous outcome and raises `chk_req` with `chk_lvl`=0 in the next cycle. While `chk_req` is high, each `chk_done` that does not end the climb raises the level by one in the following cycle. A mismatch (`chk_match`=0) does not stop the climb.
- R3: A `chk_done` with `chk_hit`=1 at a level k≥1 ends the climb. That level is neither logged nor repaired, and the descent starts at level k-1. `chk_hit` at level 0 is ignored, and that level is handled like any other fetched line.
- R4: If levels 0 to MAX_LVL (default 9) are all fetched with no on-chip hit, the descent starts at level MAX_LVL.
- R5: The descent visits levels from the top down. It raises `fix_req` only for levels whose tag mismatched, with `fix_lvl` set to that level, and it moves on only after `fix_done` with `fix_ok`=1.
- R6: `fix_data_mode` is 1 while the data line (level 0) is being repaired and 0 for every tree level.
- R7: `fix_done` with `fix_ok`=0 ends the walk in the next cycle with `result`=2 (attack). No further repair request is made.
- R8: `done` is a one-cycle pulse. `result` is 0 when no mismatch was logged and 1 when all logged levels were repaired. Bit i of `fixed_vec` is 1 exactly when level i was repaired successfully. `result` and `fixed_vec` hold until the next accepted `start`.
- R9: `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only while idle) |
| busy | output | 1 | A walk is in progress |
| chk_req | output | 1 | Tag check request for level `chk_lvl` |
| chk_lvl | output | 4 | Level being checked (0 = data line) |
| chk_done | input | 1 | Tag check response valid |
| chk_match | input | 1 | Recomputed tag equals stored tag |
| chk_hit | input | 1 | The level's entry is held on-chip |
| fix_req | output | 1 | Reconstruction request for level `fix_lvl` |
| fix_lvl | output | 4 | Level to repair |
| fix_data_mode | output | 1 | 1 = data-line repair, 0 = counter-line repair |
| fix_done | input | 1 | Reconstruction response valid |
| fix_ok | input | 1 | Reconstruction removed the mismatch |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 clean, 1 corrected, 2 attack |
| fixed_vec | output | 10 | Per-level repaired flags |

## Verification
The checker watches several rules on every cycle: a request never goes to both engines at once, the climb advances one level per response, an on-chip hit turns the walk, a failed repair becomes an attack in the next cycle, the repair mode follows the level, and a start pulse during a walk leaves the level alone. The outcome codes at `done` are also checked against `fixed_vec`. Other properties depend on the whole mismatch pattern of a walk and can only be shown by the bench's scenarios. These are the exact top-down order of repair requests, the skipping of clean levels, the start of the descent below the hit level or at the depth limit, and the contents of `fixed_vec` after an attack cuts the descent short.

// File: rtl/tfw_pkg.sv
package tfw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLIMB,
        ST_DESCEND,
        ST_REPAIR,
        ST_FINISH
    } walk_st_t;

    typedef enum logic [1:0] {
        RES_CLEAN  = 2'd0,
        RES_FIXED  = 2'd1,
        RES_ATTACK = 2'd2
    } walk_res_t;
endpackage

// File: rtl/tfw_lvl_ctr.sv
// Level pointer: cleared at walk start, stepped up while climbing, down while descending.
module tfw_lvl_ctr #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [LW-1:0] lvl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   lvl <= '0;
        else if (clr) lvl <= '0;
        else if (inc) lvl <= lvl + 1'b1;
        else if (dec) lvl <= lvl - 1'b1;
    end
endmodule

// File: rtl/tfw_flag_vec.sv
// Per-level flag storage, one flop per level, written one index at a time.
module tfw_flag_vec #(
    parameter int N  = 10,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [LW-1:0] idx,
    input  logic          val,
    output logic [N-1:0]  flags
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       flags[g] <= 1'b0;
            else if (clr)                     flags[g] <= 1'b0;
            else if (wr && idx == LW'(g))     flags[g] <= val;
        end
    end
endmodule

// File: rtl/tree_fix_walker.sv
module tree_fix_walker
    import tfw_pkg::*;
#(
    parameter int MAX_LVL = 9,
    localparam int NLV    = MAX_LVL + 1,
    localparam int LW     = $clog2(NLV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          chk_req,
    output logic [LW-1:0] chk_lvl,
    input  logic          chk_done,
    input  logic          chk_match,
    input  logic          chk_hit,
    output logic          fix_req,
    output logic [LW-1:0] fix_lvl,
    output logic          fix_data_mode,
    input  logic          fix_done,
    input  logic          fix_ok,
    output logic          done,
    output logic [1:0]    result,
    output logic [NLV-1:0] fixed_vec
);
    walk_st_t st, nxt;
    logic [LW-1:0]  lvl;
    logic [NLV-1:0] mis_log;
    logic           walk_clr, lvl_inc, lvl_dec;
    logic           log_wr, fix_wr;
    logic           res_ld;
    walk_res_t      res_val, res_q;

    tfw_lvl_ctr #(.LW(LW)) u_lvl (
        .clk(clk), .rst_n(rst_n), .clr(walk_clr),
        .inc(lvl_inc), .dec(lvl_dec), .lvl(lvl)
    );

    tfw_flag_vec #(.N(NLV), .LW(LW)) u_mis (
        .clk(clk), .rst_n(rst_n), .clr(walk_clr),
        .wr(log_wr), .idx(lvl), .val(~chk_match), .flags(mis_log)
    );

    tfw_flag_vec #(.N(NLV), .LW(LW)) u_fixed (
        .clk(clk), .rst_n(rst_n), .clr(walk_clr),
        .wr(fix_wr), .idx(lvl), .val(1'b1), .flags(fixed_vec)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Outcome register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_q <= RES_CLEAN;
        else if (walk_clr) res_q <= RES_CLEAN;
        else if (res_ld)   res_q <= res_val;
    end

    // Next state and datapath controls
    always_comb begin
        nxt      = st;
        walk_clr = 1'b0;
        lvl_inc  = 1'b0;
        lvl_dec  = 1'b0;
        log_wr   = 1'b0;
        fix_wr   = 1'b0;
        res_ld   = 1'b0;
        res_val  = RES_CLEAN;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    walk_clr = 1'b1;
                    nxt      = ST_CLIMB;
                end
            end
            ST_CLIMB: begin
                if (chk_done) begin
                    if (chk_hit && lvl != '0) begin
                        lvl_dec = 1'b1;
                        nxt     = ST_DESCEND;
                    end else begin
                        log_wr = 1'b1;
                        if (lvl == LW'(MAX_LVL)) nxt = ST_DESCEND;
                        else                     lvl_inc = 1'b1;
                    end
                end
            end
            ST_DESCEND: begin
                if (mis_log[lvl]) begin
                    nxt = ST_REPAIR;
                end else if (lvl == '0) begin
                    res_ld  = 1'b1;
                    res_val = (|mis_log) ? RES_FIXED : RES_CLEAN;
                    nxt     = ST_FINISH;
                end else begin
                    lvl_dec = 1'b1;
                end
            end
            ST_REPAIR: begin
                if (fix_done) begin
                    if (fix_ok) begin
                        fix_wr = 1'b1;
                        if (lvl == '0) begin
                            res_ld  = 1'b1;
                            res_val = RES_FIXED;
                            nxt     = ST_FINISH;
                        end else begin
                            lvl_dec = 1'b1;
                            nxt     = ST_DESCEND;
                        end
                    end else begin
                        res_ld  = 1'b1;
                        res_val = RES_ATTACK;
                        nxt     = ST_FINISH;
                    end
                end
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy          = (st != ST_IDLE);
        chk_req       = (st == ST_CLIMB);
        fix_req       = (st == ST_REPAIR);
        done          = (st == ST_FINISH);
        chk_lvl       = lvl;
        fix_lvl       = lvl;
        fix_data_mode = (st == ST_REPAIR) && (lvl == '0);
        result        = res_q;
    end
endmodule

// File: rtl/tree_fix_walker_chk.sv
module tree_fix_walker_chk #(
    parameter int MAX_LVL = 9,
    localparam int NLV    = MAX_LVL + 1,
    localparam int LW     = $clog2(NLV)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           chk_req,
    input logic [LW-1:0]  chk_lvl,
    input logic           chk_done,
    input logic           chk_match,
    input logic           chk_hit,
    input logic           fix_req,
    input logic [LW-1:0]  fix_lvl,
    input logic           fix_data_mode,
    input logic           fix_done,
    input logic           fix_ok,
    input logic           done,
    input logic [1:0]     result,
    input logic [NLV-1:0] fixed_vec
);
    p_start_climb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (chk_req && chk_lvl == '0));

    p_climb_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && chk_done && !chk_hit && chk_lvl < LW'(MAX_LVL))
        |=> (chk_req && chk_lvl == $past(chk_lvl) + 1'b1));

    p_hit_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && chk_done && chk_hit && chk_lvl != '0) |=> (!chk_req && busy));

    p_single_engine_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_req && fix_req));

    p_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fix_req |-> (fix_data_mode == (fix_lvl == '0)));

    p_attack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_req && fix_done && !fix_ok) |=> (done && result == 2'd2 && !fix_req));

    p_done_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((result == 2'd0 && fixed_vec == '0) ||
                  (result == 2'd1 && fixed_vec != '0) ||
                  (result == 2'd2)));

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && chk_req && !chk_done) |=> (chk_req && $stable(chk_lvl)));
endmodule

bind tree_fix_walker tree_fix_walker_chk #(.MAX_LVL(MAX_LVL)) u_chk (.*);

// File: tb/tree_fix_walker_bench.sv
`timescale 1ns/1ps
module tree_fix_walker_bench;
    localparam int MAXL = 9;
    localparam int NLV  = MAXL + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, chk_req, fix_req, fix_data_mode, done;
    logic [3:0] chk_lvl, fix_lvl;
    logic chk_done = 1'b0, chk_match = 1'b0, chk_hit = 1'b0;
    logic fix_done = 1'b0, fix_ok = 1'b0;
    logic [1:0] result;
    logic [NLV-1:0] fixed_vec;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int seed_dummy;

    always #5 clk = ~clk;

    tree_fix_walker #(.MAX_LVL(MAXL)) u_tree_fix_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .chk_req(chk_req), .chk_lvl(chk_lvl), .chk_done(chk_done),
        .chk_match(chk_match), .chk_hit(chk_hit),
        .fix_req(fix_req), .fix_lvl(fix_lvl), .fix_data_mode(fix_data_mode),
        .fix_done(fix_done), .fix_ok(fix_ok),
        .done(done), .result(result), .fixed_vec(fixed_vec)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // wait at negedges until some request or done is visible
    task automatic wait_evt(output bit got);
        got = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (chk_req || fix_req || done) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!got) check(1'b0, "watchdog", 0, 1);
    endtask

    // idle cycles before a response, optionally poking start while busy
    task automatic stall(input bit poke);
        int d = int'($urandom % 3);
        for (int i = 0; i < d; i++) begin
            if (poke && ($urandom % 2 == 0)) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (poke) begin
            start = 1'b1;  // present together with the response
        end
    endtask

    // expected outcome computed from the requirements
    function automatic int top_level(input int hl);
        return (hl >= 1 && hl <= MAXL) ? hl - 1 : MAXL;
    endfunction

    task automatic run_walk(input logic [NLV-1:0] mis, input int hl, input bit hit0,
                            input int failat, input bit poke);
        bit got;
        int top = top_level(hl);
        int last_up = (hl >= 1 && hl <= MAXL) ? hl : MAXL;
        logic [NLV-1:0] exp_fix = '0;
        int exp_res = 0;
        bit attacked = 1'b0;

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 climb order, R3 / R4 climb end
        for (int lv = 0; lv <= last_up; lv++) begin
            wait_evt(got);
            check(chk_req && chk_lvl == 4'(lv), (lv == last_up && hl == 0) ? "R4" : "R2",
                  {chk_req, chk_lvl}, {1'b1, 4'(lv)});
            stall(poke);
            chk_done  = 1'b1;
            chk_match = !mis[lv];
            chk_hit   = (lv == hl && hl != 0) || (lv == 0 && hit0);
            @(negedge clk);
            chk_done = 1'b0; chk_hit = 1'b0; chk_match = 1'b0; start = 1'b0;
        end
        // R5 descent order, R6 mode, R7 attack
        for (int l = top; l >= 0; l--) begin
            if (mis[l]) begin
                exp_res = 1;
                wait_evt(got);
                check(fix_req && fix_lvl == 4'(l), (hl != 0 && l == top) ? "R3" : "R5",
                      {fix_req, fix_lvl}, {1'b1, 4'(l)});
                check(fix_data_mode == (l == 0), "R6", fix_data_mode, (l == 0));
                stall(poke);
                fix_done = 1'b1;
                fix_ok   = (l != failat);
                @(negedge clk);
                fix_done = 1'b0; fix_ok = 1'b0; start = 1'b0;
                if (l == failat) begin
                    attacked = 1'b1;
                    exp_res = 2;
                    check(done && !fix_req, "R7", {done, fix_req}, 2'b10);
                    break;
                end
                exp_fix[l] = 1'b1;
            end
        end
        wait_evt(got);
        check(done && !chk_req && !fix_req, attacked ? "R7" : "R5",
              {done, chk_req, fix_req}, 3'b100);
        check(result == 2'(exp_res), poke ? "R9" : "R8", result, exp_res);
        check(fixed_vec == exp_fix, hit0 ? "R3" : "R8", fixed_vec, exp_fix);
        @(negedge clk);
        check(!done && !busy, "R8", {done, busy}, 2'b00);
        @(negedge clk);
        check(result == 2'(exp_res) && fixed_vec == exp_fix, "R8",
              {result, fixed_vec}, {2'(exp_res), exp_fix});
    endtask

    initial begin
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !chk_req && !fix_req && !done, "R1",
              {busy, chk_req, fix_req, done}, 0);
        check(result == 2'd0 && fixed_vec == '0, "R1", {result, fixed_vec}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        run_walk('0, 0, 1'b0, -1, 1'b0);                 // clean, full depth (R4)
        run_walk('1, 0, 1'b0, -1, 1'b0);                 // every level repaired
        run_walk(10'b00_0000_0011, 1, 1'b0, -1, 1'b0);   // hit at 1: only data line
        run_walk(10'b00_0000_0101, 3, 1'b1, -1, 1'b0);   // hit at 0 ignored (R3)
        run_walk(10'b00_0000_0001, 4, 1'b0, 0, 1'b0);    // data-line repair fails
        run_walk(10'b10_0000_0001, 0, 1'b0, 9, 1'b0);    // top repair fails
        run_walk(10'b00_0001_0110, 5, 1'b0, 1, 1'b1);    // mid failure, starts poked (R9)

        for (int t = 0; t < 300; t++) begin
            logic [NLV-1:0] m = NLV'($urandom);
            int hl = int'($urandom % 11);
            bit h0 = ($urandom % 5 == 0);
            int fa = ($urandom % 4 == 0) ? int'($urandom % NLV) : -1;
            bit pk = ($urandom % 4 == 0);
            if (hl == 10) hl = 0;
            run_walk(m, hl, h0, fa, pk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule